// File: doc/BRIEF.md
# Configurable SPI Master Channel

This block is one SPI master channel with a small word-wide register interface. Software sets up a configuration word (word length, clock divider, clock polarity and phase, transfer mode, chip-select level and data-pin direction), turns the channel on, and then moves words through a transmit holding register and a receive holding register. The status word tells software when the transmit register can take a new word, when a received word is waiting, and when the shift engine has gone idle.

Three transfer modes are supported. Full duplex sends and receives one word for each transmit write. Transmit-only sends and throws away whatever comes back. Receive-only starts after a single transmit write and then keeps clocking words in, driving zeros on the data output, until software turns the channel off. The chip select is not tied to the shifting. It follows a software force bit, at a level chosen by a polarity bit, so a frame can span any number of words. Either data pin can be the output.

Each SCLK half period lasts 2^code cycles of `clk`, so codes 0 through 12 give a division of the functional rate (taken as half the `clk` rate) from /1 to /4096.

Top module: `spi_chan`

## Requirements
- R1: After reset, CFG (address 0) reads 0x03C0, EN (address 1) reads 0 and STAT (address 2) reads 0x6. The low 16 bits of CFG and bit 0 of EN read back as written, and the upper bits read as zero.
- R2: CFG[11:7] holds the word length minus one. Codes 0 to 2 are taken as 4 bits. Each word makes exactly 2×length SCLK transitions and is sent MSB first from the low bits of TXD (address 3).
- R3: CFG[5:2] is the divider code, and codes above 12 act as 12. While a word is shifting, SCLK holds each level for 2^code clock cycles.
- R4: CFG[1] sets the SCLK idle level. CFG[0]=0 samples input on the first edge of each bit and changes output on the second. CFG[0]=1 changes output on the first edge and samples on the second.
- R5: With CFG[13:12]=0 (full duplex), each TXD write sends one word. The received word lands right-aligned and zero-extended in RXD (address 4), and STAT bit 0 (RXS) sets.
- R6: With CFG[13:12]=1 (receive-only), one TXD write starts reception. The channel then keeps receiving words back to back, with the data output held at 0, until EN is cleared.
- R7: With CFG[13:12]=2 (transmit-only), received data is discarded: RXS does not set and RXD keeps its value.
- R8: STAT bit 1 (TXS) clears on a TXD write and sets when the word moves into the shifter. STAT bit 2 (EOT) is 1 exactly when the shifter is idle.
- R9: Reading RXD clears RXS, unless a new word completes in the same cycle.
- R10: While EN bit 0 is 0, no word starts and SCLK stays at its idle level. Clearing EN abandons the word in flight within one cycle.
- R11: CFG[15] forces chip select active. CFG[6]=1 makes the active level low, and CFG[6]=0 makes it high.
- R12: CFG[14]=0 makes pin d1 the output and d0 the input. CFG[14]=1 swaps the two. Only the output pin has its enable set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (clears RXS on an RXD read) |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| spi_sclk | output | 1 | Serial clock |
| spi_cs | output | 1 | Chip select |
| spi_d0_o | output | 1 | Data pin 0 output value |
| spi_d0_oe | output | 1 | Data pin 0 output enable |
| spi_d0_i | input | 1 | Data pin 0 input value |
| spi_d1_o | output | 1 | Data pin 1 output value |
| spi_d1_oe | output | 1 | Data pin 1 output enable |
| spi_d1_i | input | 1 | Data pin 1 input value |

## Verification
The assertions assume that reset is held from time zero and that the bus never asks for a read and a write in the same cycle. They also assume that software does not rewrite the divider code in the middle of a word, since the tick spacing is checked against the code that is live at that moment. The stimulus respects all three. Every register access is a single strobe that lasts one cycle. CFG is rewritten only after STAT has shown the shifter idle, or with EN cleared. The serial peer in the bench is switched off while the configuration changes, so a change of SCLK idle level is never counted as a data edge.

// File: rtl/spi_chan_pkg.sv
package spi_chan_pkg;
  localparam int DW      = 32;            // data register width
  localparam int AW      = 3;             // register address width
  localparam int CFG_W   = 16;            // implemented config bits
  localparam int DIV_MAX = 12;            // largest divider code
  localparam int LEN_W   = 6;             // word length width (4..32)
  localparam int EDGE_W  = LEN_W + 1;     // SCLK transition counter width
  localparam logic [CFG_W-1:0] CFG_RST = 16'h03C0; // 8-bit words, CS active low

  typedef enum logic [AW-1:0] {
    A_CFG = 3'd0, A_EN = 3'd1, A_STAT = 3'd2, A_TXD = 3'd3, A_RXD = 3'd4
  } addr_e;

  typedef enum logic [1:0] {
    M_DUPLEX = 2'd0, M_RXONLY = 2'd1, M_TXONLY = 2'd2, M_SPARE = 2'd3
  } xfer_mode_e;

  // Packed MSB first: bit 15 down to bit 0
  typedef struct packed {
    logic       force_cs;  // 15
    logic       dir;       // 14
    xfer_mode_e mode;      // 13:12
    logic [4:0] wl;        // 11:7 length minus one
    logic       cs_low;    // 6
    logic [3:0] clkd;      // 5:2
    logic       cpol;      // 1
    logic       cpha;      // 0
  } cfg_t;

  function automatic logic [LEN_W-1:0] word_len(input logic [4:0] code);
    if (code < 5'd3) return LEN_W'(4);
    return LEN_W'(code) + LEN_W'(1);
  endfunction

  function automatic logic [3:0] div_code(input logic [3:0] code);
    if (code > 4'(DIV_MAX)) return 4'(DIV_MAX);
    return code;
  endfunction

  function automatic logic [DIV_MAX-1:0] half_limit(input logic [3:0] code);
    logic [DIV_MAX:0] one_hot;
    one_hot = (DIV_MAX+1)'(1) << div_code(code);
    return DIV_MAX'(one_hot - (DIV_MAX+1)'(1));
  endfunction
endpackage

// File: rtl/spi_chan_clkdiv.sv
module spi_chan_clkdiv
  import spi_chan_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [3:0] code,
  output logic       tick
);
  logic [DIV_MAX-1:0] cnt;
  logic [DIV_MAX-1:0] lim;

  assign lim  = half_limit(code);
  assign tick = run && (cnt == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                   cnt <= cnt + DIV_MAX'(1);
  end

  // R3: two ticks back to back only when the half period is one cycle
  p_tick_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (!tick || (lim == '0)));
endmodule

// File: rtl/spi_chan_shifter.sv
module spi_chan_shifter
  import spi_chan_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             start,
  input  logic             abort,
  input  logic [DW-1:0]    word,
  input  logic [LEN_W-1:0] len,
  input  logic             cpha,
  input  logic             cpol,
  input  logic             zero_out,
  input  logic             miso,
  output logic             busy,
  output logic             sclk,
  output logic             mosi,
  output logic             done,
  output logic [DW-1:0]    rx_word
);
  logic [LEN_W-1:0]  len_q;
  logic [EDGE_W-1:0] edge_q;
  logic              level_q, cpha_q, cpol_q;
  logic [DW-1:0]     tx_sh, rx_sh;
  logic              samp_edge, shift_edge, last_edge;

  // Named edge events for the assertions and the datapath
  assign samp_edge  = (edge_q[0] == cpha_q);
  assign shift_edge = !samp_edge && (edge_q != '0);
  assign last_edge  = (edge_q == ({len_q, 1'b0} - EDGE_W'(1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; edge_q <= '0; level_q <= 1'b0; done <= 1'b0;
      tx_sh <= '0; rx_sh <= '0; len_q <= LEN_W'(4);
      cpha_q <= 1'b0; cpol_q <= 1'b0;
    end else begin
      done <= 1'b0;
      if (abort) begin
        busy <= 1'b0; level_q <= 1'b0; edge_q <= '0;
      end else if (start) begin
        busy    <= 1'b1;
        edge_q  <= '0;
        level_q <= 1'b0;
        tx_sh   <= zero_out ? '0 : (word << (LEN_W'(DW) - len));
        rx_sh   <= '0;
        len_q   <= len;
        cpha_q  <= cpha;
        cpol_q  <= cpol;
      end else if (busy && tick) begin
        level_q <= !level_q;
        if (samp_edge)  rx_sh <= {rx_sh[DW-2:0], miso};
        if (shift_edge) tx_sh <= {tx_sh[DW-2:0], 1'b0};
        if (last_edge) begin
          busy <= 1'b0; done <= 1'b1; edge_q <= '0;
        end else begin
          edge_q <= edge_q + EDGE_W'(1);
        end
      end
    end
  end

  assign sclk    = busy ? (cpol_q ^ level_q) : cpol;
  assign mosi    = tx_sh[DW-1];
  assign rx_word = rx_sh;

  p_start_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
  p_sclk_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick && !abort) |=> $stable(sclk));
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_edge_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (edge_q < {len_q, 1'b0}));
endmodule

// File: rtl/spi_chan_regs.sv
module spi_chan_regs
  import spi_chan_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic          rd,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          load,
  input  logic          done,
  input  logic [DW-1:0] rx_word,
  input  logic          busy,
  output cfg_t          cfg,
  output logic          en,
  output logic [DW-1:0] txd,
  output logic          tx_full,
  output logic          rx_arm,
  output logic [DW-1:0] rdata
);
  logic          rx_full;
  logic [DW-1:0] rx_q;
  logic          wr_cfg, wr_en, wr_tx, rd_rx;

  assign wr_cfg = wr && (addr == A_CFG);
  assign wr_en  = wr && (addr == A_EN);
  assign wr_tx  = wr && (addr == A_TXD);
  assign rd_rx  = rd && (addr == A_RXD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= cfg_t'(CFG_RST); en <= 1'b0; txd <= '0; tx_full <= 1'b0;
      rx_q <= '0; rx_full <= 1'b0; rx_arm <= 1'b0;
    end else begin
      if (wr_cfg) cfg <= cfg_t'(wdata[CFG_W-1:0]);
      if (wr_en)  en  <= wdata[0];
      if (wr_tx) begin
        txd <= wdata; tx_full <= 1'b1;
      end else if (load) begin
        tx_full <= 1'b0;
      end
      if (done && (cfg.mode != M_TXONLY)) begin
        rx_q <= rx_word; rx_full <= 1'b1;
      end else if (rd_rx) begin
        rx_full <= 1'b0;
      end
      if (!en)                              rx_arm <= 1'b0;
      else if (load && cfg.mode == M_RXONLY) rx_arm <= 1'b1;
    end
  end

  always_comb begin
    case (addr_e'(addr))
      A_CFG:   rdata = {{(DW-CFG_W){1'b0}}, cfg};
      A_EN:    rdata = {{(DW-1){1'b0}}, en};
      A_STAT:  rdata = {{(DW-3){1'b0}}, !busy, !tx_full, rx_full};
      A_TXD:   rdata = txd;
      A_RXD:   rdata = rx_q;
      default: rdata = '0;
    endcase
  end

  p_txs_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_tx |=> tx_full);
  p_rxs_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rx && !done) |=> !rx_full);
  p_txonly_norx_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.mode == M_TXONLY && !rx_full) |=> !rx_full);
endmodule

// File: rtl/spi_chan.sv
module spi_chan
  import spi_chan_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [2:0]    bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          spi_sclk,
  output logic          spi_cs,
  output logic          spi_d0_o,
  output logic          spi_d0_oe,
  input  logic          spi_d0_i,
  output logic          spi_d1_o,
  output logic          spi_d1_oe,
  input  logic          spi_d1_i
);
  cfg_t          cfg;
  logic          en, tx_full, rx_arm, busy, done, tick, start, mosi, miso;
  logic [DW-1:0] txd, rx_word;
  logic          rx_mode;

  assign rx_mode = (cfg.mode == M_RXONLY);
  assign start   = en && !busy && (tx_full || (rx_arm && rx_mode));

  spi_chan_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .rd(bus_rd), .addr(bus_addr),
    .wdata(bus_wdata), .load(start), .done(done), .rx_word(rx_word),
    .busy(busy), .cfg(cfg), .en(en), .txd(txd), .tx_full(tx_full),
    .rx_arm(rx_arm), .rdata(bus_rdata)
  );

  spi_chan_clkdiv u_div (
    .clk(clk), .rst_n(rst_n), .run(busy), .code(cfg.clkd), .tick(tick)
  );

  spi_chan_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start(start), .abort(!en),
    .word(txd), .len(word_len(cfg.wl)), .cpha(cfg.cpha), .cpol(cfg.cpol),
    .zero_out(rx_mode), .miso(miso), .busy(busy), .sclk(spi_sclk),
    .mosi(mosi), .done(done), .rx_word(rx_word)
  );

  // Pin direction: dir=1 drives d0 and listens on d1
  assign miso      = cfg.dir ? spi_d1_i : spi_d0_i;
  assign spi_d0_o  = cfg.dir ? mosi : 1'b0;
  assign spi_d0_oe = cfg.dir;
  assign spi_d1_o  = cfg.dir ? 1'b0 : mosi;
  assign spi_d1_oe = !cfg.dir;

  // Chip select: active level is low when cs_low is set
  assign spi_cs = cfg.force_cs ? !cfg.cs_low : cfg.cs_low;

  p_disable_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !busy);
  p_rxonly_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && rx_mode) |=> !mosi);
endmodule

// File: tb/spi_chan_bench.sv
module spi_chan_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic        rst_n, wr, rd;
  logic [2:0]  addr;
  logic [31:0] wdata;
  wire  [31:0] rdata;
  wire         sclk, cs, d0_o, d0_oe, d1_o, d1_oe;
  wire         d0_i, d1_i;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit finished = 0;

  spi_chan u_spi_chan (
    .clk(clk), .rst_n(rst_n), .bus_wr(wr), .bus_rd(rd), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .spi_sclk(sclk), .spi_cs(cs),
    .spi_d0_o(d0_o), .spi_d0_oe(d0_oe), .spi_d0_i(d0_i),
    .spi_d1_o(d1_o), .spi_d1_oe(d1_oe), .spi_d1_i(d1_i)
  );

  // ---------------- expected-value functions ----------------
  function automatic int eff_len(int code);
    return (code < 3) ? 4 : code + 1;
  endfunction
  function automatic logic [31:0] lenmask(int len);
    return (len >= 32) ? 32'hFFFF_FFFF : ((32'h1 << len) - 32'h1);
  endfunction
  function automatic logic [31:0] align(logic [31:0] w, int len);
    return w << (32 - len);
  endfunction
  function automatic logic [31:0] mk_cfg(int lcode, int clkd, bit cpol, bit cpha,
                                         int mode, bit dir, bit frc, bit cs_low);
    return (32'(frc) << 15) | (32'(dir) << 14) | (32'(mode & 3) << 12) |
           (32'(lcode & 31) << 7) | (32'(cs_low) << 6) | (32'(clkd & 15) << 2) |
           (32'(cpol) << 1) | 32'(cpha);
  endfunction

  // ---------------- serial peer model ----------------
  logic        slv_on = 0;
  int          slv_len = 8, slv_pos = 0, slv_edges = 0;
  bit          slv_cpha = 0, slv_dir = 0;
  logic [31:0] slv_word = '0, slv_sh = '0, slv_rx = '0, slv_got = '0;
  wire mosi_b = slv_dir ? d0_o : d1_o;
  wire miso_b = slv_sh[31];
  assign d0_i = slv_dir ? ~miso_b : miso_b;  // wrong pin carries the inverse
  assign d1_i = slv_dir ? miso_b : ~miso_b;

  always @(sclk) if (slv_on) begin
    if ((slv_pos % 2) == int'(slv_cpha)) slv_rx = {slv_rx[30:0], mosi_b};
    else if (slv_pos != 0)               slv_sh = slv_sh << 1;
    slv_edges++;
    if (slv_pos == 2*slv_len - 1) begin
      slv_got = slv_rx; slv_rx = '0; slv_sh = align(slv_word, slv_len); slv_pos = 0;
    end else slv_pos++;
  end

  task automatic slave_start(logic [31:0] w, int len, bit cpha, bit dir);
    slv_word = w; slv_len = len; slv_cpha = cpha; slv_dir = dir;
    slv_sh = align(w, len); slv_rx = '0; slv_got = 32'hDEAD_BEEF;
    slv_pos = 0; slv_edges = 0; slv_on = 1;
  endtask

  // ---------------- bus and check tasks ----------------
  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr_reg(logic [2:0] a, logic [31:0] d);
    @(negedge clk); wr = 1; addr = a; wdata = d;
    @(negedge clk); wr = 0;
  endtask

  task automatic rd_reg(logic [2:0] a, output logic [31:0] d);
    @(negedge clk); rd = 1; addr = a; #1 d = rdata;
    @(negedge clk); rd = 0;
  endtask

  task automatic wait_flags(logic [31:0] m, int limit, output bit ok);
    logic [31:0] s;
    ok = 0;
    for (int i = 0; i < limit; i++) begin
      rd_reg(3'd2, s);
      if ((s & m) == m) begin ok = 1; break; end
    end
  endtask

  task automatic half_period(output int n);
    logic p;
    int guard;
    p = sclk; guard = 0;
    while (sclk == p && guard < 20000) begin @(negedge clk); guard++; end
    p = sclk; n = 0;
    while (sclk == p && n < 20000) begin @(negedge clk); n++; end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      summary();
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [31:0] v, tx, sw;
    bit ok, chg;
    int len, clkd, n;
    bit cpol, cpha, dir;
    logic s0;
    void'($urandom(32'd20240611));
    rst_n = 0; wr = 0; rd = 0; addr = '0; wdata = '0;
    repeat (5) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    rd_reg(3'd2, v); check("R1 stat reset", v, 32'h6);
    rd_reg(3'd0, v); check("R1 cfg reset", v, 32'h03C0);
    rd_reg(3'd1, v); check("R1 en reset", v, 32'h0);
    check("R11 cs idle high", 32'(cs), 32'h1);
    check("R4 sclk idle low", 32'(sclk), 32'h0);

    // R1 readback
    for (int i = 0; i < 3; i++) begin
      tx = $urandom;
      wr_reg(3'd0, tx); rd_reg(3'd0, v); check("R1 cfg readback", v, tx & 32'hFFFF);
    end
    wr_reg(3'd1, 32'hFFFF_FFFF); rd_reg(3'd1, v); check("R1 en readback", v, 32'h1);
    wr_reg(3'd1, 32'h0);

    // R11 chip select levels
    wr_reg(3'd0, mk_cfg(7, 0, 0, 0, 0, 0, 1, 1)); check("R11 forced low", 32'(cs), 32'h0);
    wr_reg(3'd0, mk_cfg(7, 0, 0, 0, 0, 0, 1, 0)); check("R11 forced high", 32'(cs), 32'h1);
    wr_reg(3'd0, mk_cfg(7, 0, 0, 0, 0, 0, 0, 0)); check("R11 released high-active", 32'(cs), 32'h0);

    // R12 pin direction
    wr_reg(3'd0, mk_cfg(7, 0, 0, 0, 0, 1, 0, 1));
    check("R12 dir1 enables", {30'h0, d0_oe, d1_oe}, 32'h2);
    wr_reg(3'd0, mk_cfg(7, 0, 0, 0, 0, 0, 0, 1));
    check("R12 dir0 enables", {30'h0, d0_oe, d1_oe}, 32'h1);

    // R4 idle polarity
    wr_reg(3'd0, mk_cfg(7, 0, 1, 0, 0, 0, 0, 1)); check("R4 sclk idle high", 32'(sclk), 32'h1);

    // R10 / R8 / R7: transmit-only word held back by EN=0
    wr_reg(3'd0, mk_cfg(7, 0, 0, 0, 2, 0, 1, 1));
    slave_start(32'h0, 8, 0, 0);
    wr_reg(3'd3, 32'h0000_00A5);
    rd_reg(3'd2, v); check("R8 txs clear after write", v & 32'h2, 32'h0);
    s0 = sclk; chg = 0;
    repeat (40) begin @(negedge clk); if (sclk != s0) chg = 1; end
    check("R10 no sclk while disabled", {31'h0, chg}, 32'h0);
    check("R10 no edges while disabled", 32'(slv_edges), 32'h0);
    wr_reg(3'd1, 32'h1);
    wait_flags(32'h6, 2000, ok); check("R8 txs and eot return", 32'(ok), 32'h1);
    check("R2 msb-first tx word", slv_got, 32'hA5);
    check("R2 edge count 8-bit", 32'(slv_edges), 32'd16);
    rd_reg(3'd2, v); check("R7 no rxs in tx-only", v & 32'h1, 32'h0);
    rd_reg(3'd4, v); check("R7 rxd unchanged", v, 32'h0);
    slv_on = 0;

    // R2 clamp: length code 1 acts as 4 bits
    wr_reg(3'd0, mk_cfg(1, 0, 0, 1, 0, 0, 1, 1));
    slave_start(32'h9, 4, 1, 0);
    wr_reg(3'd3, 32'hFFFF_FFF6);
    wait_flags(32'h1, 2000, ok);
    check("R2 clamp edges", 32'(slv_edges), 32'd8);
    check("R2 clamp tx", slv_got, 32'h6);
    rd_reg(3'd4, v); check("R5 clamp rx", v, 32'h9);
    slv_on = 0;

    // R5 / R2 / R4 / R12 / R9 random full-duplex words
    for (int it = 0; it < 24; it++) begin
      len  = 4 + int'($urandom % 29);
      clkd = int'($urandom % 3);
      cpol = 1'($urandom); cpha = 1'($urandom); dir = 1'($urandom);
      tx = $urandom; sw = $urandom;
      wr_reg(3'd0, mk_cfg(len - 1, clkd, cpol, cpha, 0, dir, 1, 1));
      slave_start(sw, len, cpha, dir);
      wr_reg(3'd3, tx);
      wait_flags(32'h1, 3000, ok); check("R5 rxs sets", 32'(ok), 32'h1);
      rd_reg(3'd4, v); check("R5 rx word right-aligned", v, sw & lenmask(len));
      check("R2 R4 R12 tx word seen by peer", slv_got, tx & lenmask(len));
      rd_reg(3'd2, v); check("R9 rxs cleared by read", v & 32'h1, 32'h0);
      slv_on = 0;
    end

    // R3 divider code 3
    wr_reg(3'd0, mk_cfg(7, 3, 0, 0, 2, 0, 1, 1));
    wr_reg(3'd3, 32'h5A);
    half_period(n); check("R3 half period code 3", 32'(n), 32'd8);
    wait_flags(32'h6, 2000, ok); check("R8 idle after word", 32'(ok), 32'h1);

    // R3 clamp code 15 -> 4096, then R10 abort
    wr_reg(3'd0, mk_cfg(7, 15, 0, 0, 2, 0, 1, 1));
    wr_reg(3'd3, 32'h3C);
    rd_reg(3'd2, v); check("R8 busy: eot low txs high", v & 32'h6, 32'h2);
    half_period(n); check("R3 half period clamp", 32'(n), 32'd4096);
    wr_reg(3'd1, 32'h0);
    check("R10 sclk idle after abort", 32'(sclk), 32'h0);
    rd_reg(3'd2, v); check("R10 eot after abort", v & 32'h4, 32'h4);

    // R6 receive-only
    wr_reg(3'd0, mk_cfg(7, 0, 0, 0, 1, 0, 1, 1));
    wr_reg(3'd1, 32'h1);
    slave_start(32'h3C, 8, 0, 0);
    wr_reg(3'd3, 32'hFF);
    wait_flags(32'h1, 2000, ok); check("R6 first word", 32'(ok), 32'h1);
    rd_reg(3'd4, v); check("R6 rx word", v, 32'h3C);
    check("R6 output held zero", slv_got, 32'h0);
    wait_flags(32'h1, 2000, ok); check("R6 keeps receiving", 32'(ok), 32'h1);
    rd_reg(3'd4, v); check("R6 second word", v, 32'h3C);
    slv_on = 0;
    wr_reg(3'd1, 32'h0);
    rd_reg(3'd4, v);
    repeat (100) @(negedge clk);
    rd_reg(3'd2, v); check("R6 stops after disable", v & 32'h7, 32'h6);
    check("R10 sclk idle", 32'(sclk), 32'h0);

    summary();
  end
endmodule